// File: doc/BRIEF.md
# Burst Beat Address and Lane Generator

This block turns one burst request from a memory-mapped address channel into the sequence of per-beat byte addresses and byte-lane enables that the data channel needs. A request gives a start address, a beat count minus one, a transfer-size code and a burst type. The block latches the request on a start pulse. It then presents the current beat's address and lane mask, and moves to the next beat on each advance pulse. It raises a last-beat flag while the final beat is presented.

The block checks each request at the moment it arrives. An incrementing burst whose bytes would run past a 4 KB page, a wrapping request with an illegal length or a misaligned start, the reserved burst code, and a transfer size wider than the data bus are all refused. In each case an error flag is set and no beats are produced. The total byte count of the burst is reported for every request. A data mover steps the block once per accepted data beat and uses the outputs to steer its byte lanes.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, busy, last_beat, lane_en, beat_addr, total_bytes and all three error flags are zero.
- R2: A start pulse while idle latches the request, and total_bytes becomes (req_len+1) times 2^req_size on the next cycle. If the request is legal, busy rises on that same cycle and beat_addr equals req_addr. A start pulse while busy is ignored.
- R3: Burst code 2'b00 (fixed) presents the same address and the same lane mask on every beat. With req_len = 0 it gives the same address and mask as code 2'b01.
- R4: Burst code 2'b01 (incrementing) with a size-aligned start adds 2^req_size to the address on each advance.
- R5: With an incrementing burst that starts on an unaligned address, the first beat uses the given address and the second beat uses the next 2^req_size-aligned address (start 0x1 at size code 2 gives 0x4 next).
- R6: Burst code 2'b10 (wrapping) keeps the address inside a window of (req_len+1)·2^req_size bytes aligned to that size. Start 0x1018 with size code 2 and req_len 3 gives 0x1018, 0x101C, 0x1010, 0x1014.
- R7: lane_en bit i enables byte lane i, counted little-endian from the bus's low byte. The enabled lanes run from address mod bus-bytes up to the end of the 2^req_size-byte container that holds that address. On a 64-bit bus, size code 0 at 0x1 gives 0x02, size code 2 at 0x4 gives 0xF0, and size code 2 at 0x1 gives 0x0E. lane_en is zero while idle.
- R8: last_beat is high exactly while the final beat is presented. An advance on that beat returns the block to idle on the next cycle. An advance while idle is ignored.
- R9: An incrementing request whose bytes, from the start address to the end of its last container, cross a 4 KB boundary sets err_4k and produces no beats.
- R10: A wrapping request whose req_len is not 1, 3, 7 or 15, or whose start is not 2^req_size-aligned, and any request with burst code 2'b11, sets err_mode and produces no beats.
- R11: A req_size code above log2 of the bus width in bytes sets err_size and produces no beats.
- R12: The error flags hold until the next start accepted while idle, which replaces them with that request's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request valid pulse, taken only while idle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Beat count minus one |
| req_size | input | 3 | Bytes per beat as a power of two |
| req_burst | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| advance | input | 1 | Current beat consumed |
| busy | output | 1 | A burst is being walked |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| lane_en | output | DATA_BYTES | Byte-lane enables of the current beat |
| last_beat | output | 1 | Current beat is the final one |
| total_bytes | output | LEN_W+8 | Byte count of the latest request |
| err_4k | output | 1 | Incrementing request crossed a 4 KB page |
| err_mode | output | 1 | Illegal wrap request or reserved burst code |
| err_size | output | 1 | Transfer size wider than the bus |

## Verification
Accepting a new request and retiring the final beat of the current one can fall in the same cycle. This happens when a start pulse arrives together with the advance that consumes the last beat. The bench provokes it by driving start with a fresh legal request on the same clock as that final advance. It then requires busy to be low on the next cycle and to stay low, because the start was seen while the block was still busy and must have been dropped. A fresh start on the following cycle must then be accepted normally.

// File: rtl/bag_pkg.sv
// Shared types for the burst beat address generator.
// Assumes burst codes follow the common two-bit encoding.
package bag_pkg;
    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_e;
endpackage

// File: rtl/bag_req_check.sv
// Request screening: computes the byte total and the wrap window mask,
// and flags 4 KB crossings, illegal wrap or reserved modes and oversize
// transfers. Purely combinational. Assumes ADDR_W >= 12 and TOT_W >= 12.
module bag_req_check
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int LANE_W = 3,
    parameter int TOT_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [2:0]        size,
    input  burst_e            burst,
    output logic [TOT_W-1:0]  total,
    output logic [ADDR_W-1:0] wrap_mask,
    output logic              bad_4k,
    output logic              bad_mode,
    output logic              bad_size
);
    logic [ADDR_W-1:0] size_mask;
    logic [TOT_W:0]    end_off;
    logic              len_ok;

    // Byte total, wrap window and size alignment mask.
    always_comb begin
        total     = ({{(TOT_W-LEN_W){1'b0}}, len} + TOT_W'(1)) << size;
        wrap_mask = ADDR_W'(total) - ADDR_W'(1);
        size_mask = (ADDR_W'(1) << size) - ADDR_W'(1);
    end

    // Offset of the final byte measured from the start of the 4 KB page.
    always_comb begin
        end_off = {{(TOT_W-11){1'b0}}, addr[11:0] & ~size_mask[11:0]}
                + {1'b0, total} - (TOT_W+1)'(1);
    end

    // Legality decisions.
    always_comb begin
        len_ok   = (len == LEN_W'(1)) || (len == LEN_W'(3)) ||
                   (len == LEN_W'(7)) || (len == LEN_W'(15));
        bad_4k   = (burst == BURST_INCR) && (end_off[TOT_W:12] != '0);
        bad_mode = (burst == BURST_RSVD) ||
                   ((burst == BURST_WRAP) &&
                    (!len_ok || ((addr & size_mask) != '0)));
        bad_size = (size > 3'(LANE_W));
    end
endmodule

// File: rtl/bag_next_addr.sv
// Next-beat address for fixed, incrementing and wrapping bursts.
// Assumes wrap starts are size-aligned (screened at request time).
module bag_next_addr
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [2:0]        size,
    input  burst_e            burst,
    input  logic [ADDR_W-1:0] wrap_mask,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] step_mask;

    // Select the successor address by burst type.
    always_comb begin
        step      = ADDR_W'(1) << size;
        step_mask = step - ADDR_W'(1);
        case (burst)
            BURST_FIXED: nxt = cur;
            BURST_WRAP:  nxt = (cur & ~wrap_mask) | ((cur + step) & wrap_mask);
            default:     nxt = (cur & ~step_mask) + step;
        endcase
    end
endmodule

// File: rtl/bag_lane_mask.sv
// Byte-lane enables: lanes from the address offset to the end of the
// size-aligned container. Assumes DATA_BYTES >= 2 and a legal size.
module bag_lane_mask #(
    parameter int DATA_BYTES = 8,
    parameter int LANE_W     = 3
) (
    input  logic [LANE_W-1:0]     offset,
    input  logic [2:0]            size,
    input  logic                  enable,
    output logic [DATA_BYTES-1:0] lanes
);
    logic [LANE_W:0] lo;
    logic [LANE_W:0] hi;
    logic [LANE_W:0] sz;

    // Lane window bounds.
    always_comb begin
        sz = (LANE_W+1)'(1) << size;
        lo = {1'b0, offset};
        hi = (lo & ~(sz - (LANE_W+1)'(1))) + sz;
    end

    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
        // One enable per byte lane.
        assign lanes[i] = enable && ((LANE_W+1)'(i) >= lo) && ((LANE_W+1)'(i) < hi);
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Burst beat address generator top. Accepts a request while idle,
// refuses illegal ones with a flag, and walks the beats on advance.
// Assumes advance is only meaningful while busy.
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 8,
    parameter int LEN_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic [2:0]            req_size,
    input  logic [1:0]            req_burst,
    input  logic                  advance,
    output logic                  busy,
    output logic [ADDR_W-1:0]     beat_addr,
    output logic [DATA_BYTES-1:0] lane_en,
    output logic                  last_beat,
    output logic [LEN_W+7:0]      total_bytes,
    output logic                  err_4k,
    output logic                  err_mode,
    output logic                  err_size
);
    localparam int LANE_W = $clog2(DATA_BYTES);
    localparam int TOT_W  = LEN_W + 8;

    logic              busy_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [2:0]        cur_size;
    burst_e            cur_burst;
    logic [ADDR_W-1:0] wrap_mask_q;
    logic [TOT_W-1:0]  total_q;
    logic              e4k_q, emode_q, esize_q;

    logic [TOT_W-1:0]  chk_total;
    logic [ADDR_W-1:0] chk_wmask;
    logic              bad_4k, bad_mode, bad_size;
    logic [ADDR_W-1:0] nxt_addr;

    bag_req_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANE_W(LANE_W), .TOT_W(TOT_W)) u_check (
        .addr(req_addr), .len(req_len), .size(req_size), .burst(burst_e'(req_burst)),
        .total(chk_total), .wrap_mask(chk_wmask),
        .bad_4k(bad_4k), .bad_mode(bad_mode), .bad_size(bad_size)
    );

    bag_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .cur(cur_addr), .size(cur_size), .burst(cur_burst),
        .wrap_mask(wrap_mask_q), .nxt(nxt_addr)
    );

    bag_lane_mask #(.DATA_BYTES(DATA_BYTES), .LANE_W(LANE_W)) u_lanes (
        .offset(cur_addr[LANE_W-1:0]), .size(cur_size), .enable(busy_q), .lanes(lane_en)
    );

    // Request acceptance and beat stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            cur_addr    <= '0;
            remain      <= '0;
            cur_size    <= '0;
            cur_burst   <= BURST_FIXED;
            wrap_mask_q <= '0;
            total_q     <= '0;
            e4k_q       <= 1'b0;
            emode_q     <= 1'b0;
            esize_q     <= 1'b0;
        end else if (!busy_q && start) begin
            total_q <= chk_total;
            e4k_q   <= bad_4k;
            emode_q <= bad_mode;
            esize_q <= bad_size;
            if (!(bad_4k || bad_mode || bad_size)) begin
                busy_q      <= 1'b1;
                cur_addr    <= req_addr;
                remain      <= req_len;
                cur_size    <= req_size;
                cur_burst   <= burst_e'(req_burst);
                wrap_mask_q <= chk_wmask;
            end
        end else if (busy_q && advance) begin
            if (remain == '0) begin
                busy_q <= 1'b0;
            end else begin
                cur_addr <= nxt_addr;
                remain   <= remain - LEN_W'(1);
            end
        end
    end

    // Output mapping.
    always_comb begin
        busy        = busy_q;
        beat_addr   = cur_addr;
        last_beat   = busy_q && (remain == '0);
        total_bytes = total_q;
        err_4k      = e4k_q;
        err_mode    = emode_q;
        err_size    = esize_q;
    end
endmodule

// File: rtl/bag_checker.sv
// Protocol checks for burst_addr_gen, attached by bind.
// Assumes it sees the top's ports plus its latched size and burst type.
module bag_checker #(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     req_addr,
    input logic                  advance,
    input logic                  busy,
    input logic [ADDR_W-1:0]     beat_addr,
    input logic [DATA_BYTES-1:0] lane_en,
    input logic                  last_beat,
    input logic                  err_4k,
    input logic                  err_mode,
    input logic                  err_size,
    input logic [1:0]            cur_burst,
    input logic [2:0]            cur_size
);
    logic [ADDR_W-1:0] step;
    // Beat stride of the burst in flight.
    always_comb step = ADDR_W'(1) << cur_size;

    // R2: a fresh burst starts on the requested address.
    a_r2_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> beat_addr == $past(req_addr));

    // R3: fixed bursts never move.
    a_r3_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy && advance && !last_beat && cur_burst == 2'b00
        |=> $stable(beat_addr) && $stable(lane_en));

    // R4: aligned incrementing beats step by the transfer size.
    a_r4_incr_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy && advance && !last_beat && cur_burst == 2'b01 &&
        ((beat_addr & (step - ADDR_W'(1))) == '0)
        |=> beat_addr == $past(beat_addr + step));

    // R7: no lanes driven while idle, some lane while busy.
    a_r7_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        busy ? (lane_en != '0) : (lane_en == '0));

    // R8: final advance returns to idle; last only while busy.
    a_r8_last_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy && last_beat && advance |=> !busy);
    a_r8_last_busy: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> busy);

    // R9 R10 R11: a refused request produces no beats.
    a_r9_refused_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (err_4k || err_mode || err_size) |-> !busy);
endmodule

bind burst_addr_gen bag_checker #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .advance(advance),
    .busy(busy), .beat_addr(beat_addr), .lane_en(lane_en), .last_beat(last_beat),
    .err_4k(err_4k), .err_mode(err_mode), .err_size(err_size),
    .cur_burst(cur_burst), .cur_size(cur_size)
);

// File: tb/burst_addr_gen_test.sv
// Directed bench for burst_addr_gen on a 64-bit bus.
module burst_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [2:0]  req_size = '0;
    logic [1:0]  req_burst = '0;
    logic        advance = 1'b0;
    logic        busy, last_beat, err_4k, err_mode, err_size;
    logic [31:0] beat_addr;
    logic [7:0]  lane_en;
    logic [15:0] total_bytes;
    int n_checks = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    burst_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
        .req_len(req_len), .req_size(req_size), .req_burst(req_burst),
        .advance(advance), .busy(busy), .beat_addr(beat_addr), .lane_en(lane_en),
        .last_beat(last_beat), .total_bytes(total_bytes),
        .err_4k(err_4k), .err_mode(err_mode), .err_size(err_size)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present a request for one cycle; returns at the cycle it took effect.
    task automatic issue(input logic [31:0] a, input logic [7:0] l,
                         input logic [2:0] s, input logic [1:0] b);
        @(negedge clk);
        req_addr = a; req_len = l; req_size = s; req_burst = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Check the presented beat, then consume it.
    task automatic beat(input string req, input logic [31:0] a,
                        input logic [7:0] lanes, input logic last);
        check({req, " addr"}, beat_addr, a);
        check({req, " lanes"}, lane_en, lanes);
        check({req, " last"}, last_beat, last);
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 last", last_beat, 0);
        check("R1 lanes", lane_en, 0);
        check("R1 addr", beat_addr, 0);
        check("R1 total", total_bytes, 0);
        check("R1 errs", {err_4k, err_mode, err_size}, 0);
    endtask

    task automatic t_incr_aligned();
        issue(32'h100, 8'd3, 3'd3, 2'b01);
        check("R2 busy", busy, 1);
        check("R2 total", total_bytes, 32);
        beat("R4 b0", 32'h100, 8'hFF, 0);
        beat("R4 b1", 32'h108, 8'hFF, 0);
        beat("R4 b2", 32'h110, 8'hFF, 0);
        beat("R4 b3", 32'h118, 8'hFF, 1);
        check("R8 idle after last", busy, 0);
    endtask

    task automatic t_incr_unaligned();
        issue(32'h1, 8'd2, 3'd2, 2'b01);
        check("R2 total", total_bytes, 12);
        beat("R5 R7 first", 32'h1, 8'h0E, 0);
        beat("R5 second", 32'h4, 8'hF0, 0);
        beat("R5 third", 32'h8, 8'h0F, 1);
        check("R8 idle", busy, 0);
    endtask

    task automatic t_narrow_single();
        issue(32'h1, 8'd0, 3'd0, 2'b00);
        beat("R7 byte lane1 fixed", 32'h1, 8'h02, 1);
        issue(32'h1, 8'd0, 3'd0, 2'b01);
        beat("R3 single incr same", 32'h1, 8'h02, 1);
        issue(32'h4, 8'd0, 3'd2, 2'b01);
        beat("R7 upper word", 32'h4, 8'hF0, 1);
        check("R8 idle", busy, 0);
    endtask

    task automatic t_fixed();
        issue(32'h203, 8'd3, 3'd0, 2'b00);
        for (int i = 0; i < 4; i++) beat("R3 fixed", 32'h203, 8'h08, i == 3);
    endtask

    task automatic t_wrap();
        issue(32'h1018, 8'd3, 3'd2, 2'b10);
        check("R6 total", total_bytes, 16);
        beat("R6 b0", 32'h1018, 8'h0F, 0);
        beat("R6 b1", 32'h101C, 8'hF0, 0);
        beat("R6 b2", 32'h1010, 8'h0F, 0);
        beat("R6 b3", 32'h1014, 8'hF0, 1);
    endtask

    task automatic t_4k();
        issue(32'hFF8, 8'd1, 3'd3, 2'b01);
        check("R9 flag", err_4k, 1);
        check("R9 no beats", busy, 0);
        check("R9 lanes", lane_en, 0);
        issue(32'hFF0, 8'd1, 3'd3, 2'b01);
        check("R9 R12 edge ok flag", err_4k, 0);
        beat("R9 edge b0", 32'hFF0, 8'hFF, 0);
        beat("R9 edge b1", 32'hFF8, 8'hFF, 1);
    endtask

    task automatic t_mode();
        issue(32'h1000, 8'd2, 3'd2, 2'b10);
        check("R10 wrap len", err_mode, 1);
        check("R10 no beats", busy, 0);
        issue(32'h1019, 8'd3, 3'd2, 2'b10);
        check("R10 wrap unaligned", err_mode, 1);
        @(negedge clk);
        check("R12 flag held", err_mode, 1);
        issue(32'h0, 8'd0, 3'd0, 2'b11);
        check("R10 reserved", err_mode, 1);
        check("R10 reserved idle", busy, 0);
    endtask

    task automatic t_size();
        issue(32'h0, 8'd0, 3'd4, 2'b01);
        check("R11 flag", err_size, 1);
        check("R11 no beats", busy, 0);
        issue(32'h40, 8'd0, 3'd3, 2'b01);
        check("R12 cleared", {err_4k, err_mode, err_size}, 0);
        beat("R12 good after error", 32'h40, 8'hFF, 1);
    endtask

    task automatic t_overlap();
        issue(32'h300, 8'd1, 3'd3, 2'b01);
        issue(32'h800, 8'd0, 3'd3, 2'b01);
        check("R2 start while busy ignored", beat_addr, 32'h300);
        beat("R4 b0", 32'h300, 8'hFF, 0);
        // Final advance together with a new start: start must be dropped.
        req_addr = 32'h900; req_len = 8'd0; req_size = 3'd3; req_burst = 2'b01;
        start = 1'b1; advance = 1'b1;
        @(negedge clk);
        start = 1'b0; advance = 1'b0;
        check("R2 R8 start on last dropped", busy, 0);
        @(negedge clk);
        check("R2 still idle", busy, 0);
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        check("R8 advance idle ignored", busy, 0);
        check("R8 addr held idle", beat_addr, 32'h308);
        issue(32'h900, 8'd0, 3'd3, 2'b01);
        beat("R2 next accepted", 32'h900, 8'hFF, 1);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_incr_aligned();
        t_incr_unaligned();
        t_narrow_single();
        t_fixed();
        t_wrap();
        t_4k();
        t_mode();
        t_size();
        t_overlap();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule